// File: doc/BRIEF.md
# Spread Spectrum Triangle Profile Generator

This block produces the digital frequency-deviation word that steers the fractional feedback divider of a spread-spectrum clock synthesizer. It runs on the reference clock. The deviation follows a linear triangle that is centred on zero. It climbs to a positive peak, descends to the mirror-image negative peak, and returns. The triangle period is a fixed number of reference cycles. A two-bit range select chooses that number and also chooses whether the synthesizer multiplies by one or by two.

The peak is set by an unsigned amplitude code. The profile is built on an internal level that walks between -583 and +583. With the default short count of 1166 the level moves 2 per cycle. With the long count of 2332 it moves 1 per cycle. The output word is the amplitude times the level, divided by 583 and truncated toward zero.

Dropping the modulation enable parks the deviation at zero, which gives a plain carrier. Selecting the unsupported range does the same and also raises a flag. In both cases the walk restarts from zero, going upward, once modulation is allowed again.

Top module: `ssc_profile_gen`

## Requirements
- R1: While rst_ni is low, dev_o, mult2x_o and range_bad_o are all 0.
- R2: Range code 00 gives a sweep period of 1166 cycles. The level after k active clock edges since restart is T(2k mod 2332), where T(x) = x for x<=583, 1166-x for x<=1749, and x-2332 otherwise. dev_o = (amp_i*T)/583, truncated toward zero. mult2x_o is 0.
- R3: Range code 01 gives the same profile and period as code 00, and mult2x_o is 1.
- R4: Range code 10 gives a sweep period of 2332 cycles, using the level T(k mod 2332) with step 1. It reaches exactly +amp_i and -amp_i. mult2x_o is 0.
- R5: Range code 11 sets range_bad_o to 1 and dev_o to 0 on the next clock. After leaving code 11, the sweep restarts from zero, going upward.
- R6: When mod_en_i is low, dev_o is 0 on the next clock. When mod_en_i is raised again, the first active edge gives the level +step, so the sweep restarts from zero, going upward.
- R7: The sweep is centred on zero. Over one period, the largest dev_o equals minus the smallest dev_o.
- R8: With amp_i = 583, dev_o rises on as many cycles of one period as it falls. The level never moves by more than 2 per cycle.
- R9: Every output is registered. A change on amp_i or range_sel_i takes effect on the next clock edge, and the sweep phase continues without a restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| range_sel_i | input | 2 | Range code: 00 short 1X, 01 short 2X, 10 long 1X, 11 unsupported |
| mod_en_i | input | 1 | Modulation enable, high runs the sweep |
| amp_i | input | AMP_W | Peak deviation code, unsigned |
| dev_o | output | AMP_W+1 | Signed frequency-deviation word |
| mult2x_o | output | 1 | Multiplier select, 1 selects 2X |
| range_bad_o | output | 1 | Unsupported range code applied |

## Verification
The main collision is a peak reflection that falls on the same clock edge as a disable, or as a range change. To provoke it, the bench restarts a short sweep and advances exactly 291 edges to the top of the triangle. On the reflecting edge it drops the enable and applies code 11 together; in a second run it switches to code 01 on that edge instead. The judgment is that the disable wins, giving zero deviation and the flag raised, and that a range change continues from the reflected level (582) with the new multiplier. A cycle-by-cycle model built on the closed-form triangle is compared on every clock throughout.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic [1:0] {
    RNG_SHORT_1X = 2'b00,
    RNG_SHORT_2X = 2'b01,
    RNG_LONG_1X  = 2'b10,
    RNG_NONE     = 2'b11
  } rng_e;
endpackage

// File: rtl/ssc_range_decode.sv
module ssc_range_decode
  import ssc_pkg::*;
(
  input  logic [1:0] range_i,
  output logic [1:0] step_o,
  output logic       mult2x_o,
  output logic       bad_o
);
  always_comb begin
    step_o   = 2'd2;
    mult2x_o = 1'b0;
    bad_o    = 1'b0;
    unique case (rng_e'(range_i))
      RNG_SHORT_1X: ;
      RNG_SHORT_2X: mult2x_o = 1'b1;
      RNG_LONG_1X:  step_o = 2'd1;
      RNG_NONE: begin
        step_o = 2'd0;
        bad_o  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ssc_tri_walker.sv
module ssc_tri_walker #(
  parameter int PEAK  = 583,
  parameter int LVL_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    active_i,
  input  logic [1:0]              step_i,
  output logic signed [LVL_W-1:0] nxt_o,
  output logic signed [LVL_W-1:0] lvl_o
);
  localparam logic signed [LVL_W-1:0] PK  = LVL_W'(PEAK);
  localparam logic signed [LVL_W-1:0] PK2 = LVL_W'(2 * PEAK);

  logic signed [LVL_W-1:0] lvl_q, stp, sum;
  logic                    up_q, flip;

  assign stp = {{(LVL_W-2){1'b0}}, step_i};
  assign sum = up_q ? lvl_q + stp : lvl_q - stp;

  // reflect about the peak so the walk stays inside [-PK, PK]
  always_comb begin
    flip  = 1'b0;
    nxt_o = sum;
    if (sum > PK) begin
      nxt_o = PK2 - sum;
      flip  = 1'b1;
    end else if (sum < -PK) begin
      nxt_o = -PK2 - sum;
      flip  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      up_q  <= 1'b1;
    end else if (!active_i) begin
      lvl_q <= '0;
      up_q  <= 1'b1;
    end else begin
      lvl_q <= nxt_o;
      up_q  <= up_q ^ flip;
    end
  end

  assign lvl_o = lvl_q;

  assert_lvl_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q <= PK) && (lvl_q >= -PK));

  assert_lvl_slew_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(active_i) |-> (((lvl_q - $past(lvl_q)) <= 2) && ((lvl_q - $past(lvl_q)) >= -2)));

  assert_lvl_park_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (lvl_q == '0));
endmodule

// File: rtl/ssc_dev_scale.sv
module ssc_dev_scale #(
  parameter int PEAK  = 583,
  parameter int AMP_W = 10,
  parameter int LVL_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    active_i,
  input  logic [AMP_W-1:0]        amp_i,
  input  logic signed [LVL_W-1:0] lvl_i,
  output logic signed [AMP_W:0]   dev_o
);
  localparam int PROD_W = AMP_W + LVL_W + 1;
  localparam logic signed [PROD_W-1:0] DIV = PROD_W'(PEAK);

  logic signed [PROD_W-1:0] prod, quo;
  logic signed [AMP_W:0]    dev_q;

  assign prod = PROD_W'($signed({1'b0, amp_i})) * PROD_W'(lvl_i);
  // signed divide truncates toward zero, keeping the profile symmetric
  assign quo  = prod / DIV;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        dev_q <= '0;
    else if (!active_i) dev_q <= '0;
    else                dev_q <= (AMP_W+1)'(quo);
  end

  assign dev_o = dev_q;
endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen #(
  parameter int BASE_DIV = 1166,
  parameter int AMP_W    = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            range_sel_i,
  input  logic                  mod_en_i,
  input  logic [AMP_W-1:0]      amp_i,
  output logic signed [AMP_W:0] dev_o,
  output logic                  mult2x_o,
  output logic                  range_bad_o
);
  localparam int PEAK  = BASE_DIV / 2;
  localparam int LVL_W = $clog2(2 * PEAK + 3) + 1;

  logic [1:0]              step;
  logic                    mult_c, bad_c, active;
  logic signed [LVL_W-1:0] lvl_nxt, lvl_q;
  logic                    mult_q, bad_q;

  ssc_range_decode u_dec (
    .range_i  (range_sel_i),
    .step_o   (step),
    .mult2x_o (mult_c),
    .bad_o    (bad_c)
  );

  assign active = mod_en_i & ~bad_c;

  ssc_tri_walker #(.PEAK(PEAK), .LVL_W(LVL_W)) u_walk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .step_i   (step),
    .nxt_o    (lvl_nxt),
    .lvl_o    (lvl_q)
  );

  ssc_dev_scale #(.PEAK(PEAK), .AMP_W(AMP_W), .LVL_W(LVL_W)) u_scale (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .amp_i    (amp_i),
    .lvl_i    (lvl_nxt),
    .dev_o    (dev_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mult_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      mult_q <= mult_c;
      bad_q  <= bad_c;
    end
  end

  assign mult2x_o    = mult_q;
  assign range_bad_o = bad_q;

  assert_bad_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (range_sel_i == 2'b11) |=> (range_bad_o && (dev_o == '0)));

  assert_disable_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mod_en_i |=> (dev_o == '0));

  assert_mult_sel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (range_sel_i == 2'b01) |=> mult2x_o);

  assert_sign_track_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_o != '0) |-> (dev_o[AMP_W] == lvl_q[LVL_W-1]));
endmodule

// File: tb/ssc_profile_gen_tb.sv
`timescale 1ns/1ps
module ssc_profile_gen_tb;
  localparam int PK   = 583;
  localparam int AMPW = 10;

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic [1:0]           rng = 2'b00;
  logic                 en = 1'b0;
  logic [AMPW-1:0]      amp = '0;
  logic signed [AMPW:0] dev;
  logic                 mult, bad;

  int    checks = 0, errors = 0;
  string tag = "R1";
  bit    model_on = 1'b0, done = 1'b0;
  int    k = 0, exp_dev = 0, stp = 2;
  bit    exp_mult = 1'b0, exp_bad = 1'b0, act = 1'b0;
  int    mx, mn, ups, downs;

  always #2.5 clk = ~clk;

  ssc_profile_gen u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .range_sel_i(rng), .mod_en_i(en),
    .amp_i(amp), .dev_o(dev), .mult2x_o(mult), .range_bad_o(bad)
  );

  function automatic int tri_f(int x);
    if (x <= PK) return x;
    else if (x <= 3 * PK) return 2 * PK - x;
    else return x - 4 * PK;
  endfunction

  task automatic chk(string req, string what, int got, int want);
    checks++;
    if (got != want) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, want);
    end
  endtask

  // behavioural reference: closed-form triangle on edges since restart
  always @(posedge clk) begin
    if (!rst_ni) begin
      k = 0; exp_dev = 0; exp_mult = 0; exp_bad = 0; model_on = 0;
    end else begin
      act = en && (rng != 2'b11);
      stp = (rng == 2'b10) ? 1 : 2;
      k   = act ? k + 1 : 0;
      exp_dev  = act ? (int'(amp) * tri_f((stp * k) % (4 * PK))) / PK : 0;
      exp_mult = (rng == 2'b01);
      exp_bad  = (rng == 2'b11);
      model_on = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_ni && model_on && !done) begin
      chk(tag, "dev", int'(dev), exp_dev);
      chk(tag, "mult", int'(mult), int'(exp_mult));
      chk(tag, "bad", int'(bad), int'(exp_bad));
    end
  end

  task automatic go(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic measure(int n);
    int prev;
    prev = int'(dev); mx = prev; mn = prev; ups = 0; downs = 0;
    for (int i = 0; i < n; i++) begin
      go(1);
      if (int'(dev) > prev) ups++;
      if (int'(dev) < prev) downs++;
      if (int'(dev) > mx) mx = int'(dev);
      if (int'(dev) < mn) mn = int'(dev);
      prev = int'(dev);
    end
  endtask

  task automatic restart(logic [1:0] r, int a);
    en = 1'b0; go(1);
    rng = r; amp = AMPW'(a); en = 1'b1;
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rng = 2'b01; en = 1'b1; amp = 10'd500;
    go(3);
    chk("R1", "dev in reset", int'(dev), 0);
    chk("R1", "mult in reset", int'(mult), 0);
    chk("R1", "bad in reset", int'(bad), 0);
    en = 1'b0; rng = 2'b00;
    rst_ni = 1'b1;
    go(2);

    // R2 / R7 / R8: short range, amp equal to peak
    tag = "R2";
    restart(2'b00, 583);
    measure(1166);
    chk("R2", "dev after one period", int'(dev), 0);
    chk("R7", "max+min short", mx + mn, 0);
    chk("R7", "max short", mx, 582);
    chk("R8", "rises minus falls short", ups - downs, 0);
    go(10);

    // R6: disable then re-enable restarts upward
    tag = "R6";
    en = 1'b0; go(1);
    chk("R6", "dev disabled", int'(dev), 0);
    go(4);
    en = 1'b1; go(1);
    chk("R6", "first step after enable", int'(dev), 2);
    go(1);
    chk("R6", "second step after enable", int'(dev), 4);

    // R3: 2X short range
    tag = "R3";
    restart(2'b01, 300);
    go(1);
    chk("R3", "mult 2X", int'(mult), 1);
    measure(1165);
    chk("R3", "dev after one period", int'(dev), 0);
    chk("R7", "max+min 2X", mx + mn, 0);

    // R9: amplitude changes mid sweep, phase continues
    tag = "R9";
    go(100);
    amp = 10'd1000; go(1);
    chk("R9", "amp step", int'(dev), (1000 * tri_f((2 * 101) % 2332)) / PK);
    go(50);

    // R4: long range
    tag = "R4";
    restart(2'b10, 583);
    measure(2332);
    chk("R4", "max long", mx, 583);
    chk("R4", "min long", mn, -583);
    chk("R4", "dev after one period", int'(dev), 0);
    chk("R8", "rises long", ups, 1166);
    chk("R8", "falls long", downs, 1166);
    restart(2'b10, 1023);
    measure(2332);
    chk("R4", "max full code", mx, 1023);
    chk("R7", "max+min full code", mx + mn, 0);

    // R5: unsupported range mid sweep
    tag = "R5";
    go(300);
    rng = 2'b11; go(1);
    chk("R5", "bad flag", int'(bad), 1);
    chk("R5", "dev held", int'(dev), 0);
    go(5);
    chk("R5", "dev still held", int'(dev), 0);
    rng = 2'b10; go(1);
    chk("R5", "bad cleared", int'(bad), 0);
    chk("R5", "restart upward", int'(dev), 1);

    // collision: disable and bad range on the reflecting edge
    tag = "R6";
    restart(2'b00, 583);
    go(291);
    chk("R2", "top before reflect", int'(dev), 582);
    en = 1'b0; rng = 2'b11; go(1);
    chk("R6", "disable at reflect", int'(dev), 0);
    chk("R5", "bad at reflect", int'(bad), 1);
    rng = 2'b00; en = 1'b1; go(1);
    chk("R6", "restart after collision", int'(dev), 2);

    // collision: range change on the reflecting edge
    tag = "R9";
    restart(2'b00, 583);
    go(291);
    rng = 2'b01; go(1);
    chk("R9", "reflect with range change", int'(dev), 582);
    chk("R3", "mult on reflect edge", int'(mult), 1);
    go(1);
    chk("R9", "descending after change", int'(dev), 580);
    go(5);

    finish_run();
  end
endmodule